// File: doc/BRIEF.md
# Compare-and-Swap Memory Sequencer

This block carries out one atomic compare-and-swap against a small local data memory that is organised in wide lines. A request brings three operands in a fixed order: the value the caller expects, a byte pointer, and the value that should replace the expected one. The sequencer reads the whole line that holds the pointed word and picks the word out of that line. It compares the word with the expected value. On a match it merges the replacement into the line and writes the line back. The caller always receives the word that was found in memory, together with a status code that is zero only when the swap took effect.

Ordinary word stores from any agent reach the same memory through a separate store port, and each one commits in the cycle it is presented. Every line carries a reservation flag. A compare-and-swap read sets the flag of its line, and any store to that line clears it. The flag is checked again at write-back, so a store that lands between the read and the write cancels the swap. The write-back comes later than the slot used by ordinary stores. For that reason the sequencer raises a stall in its write cycle, and the issuer must not present a store while the stall is high. Only one operation can be in flight, and a request arriving while the sequencer is busy is dropped.

Top module: `cas_seq`

## Requirements
- R1: After reset, `busy`, `done`, `store_stall` and `align_err` are low, and every memory word reads as zero.
- R2: A request is accepted on a rising edge where `start` is high and `busy` is low. Its operands are `exp_val` (expected), `ptr` (byte pointer) and `new_val` (replacement). The line index is `ptr[7:5]` and the word select within the 256-bit line is `ptr[4:3]`. On a successful swap only that 64-bit word changes, and the other three words of the line keep their values.
- R3: `old_val` returns the 64-bit word read from memory. `status` is 0 (success) when that word equals `exp_val` and the line was not written during the operation.
- R4: When the word found differs from `exp_val`, nothing is written and `status` is 1.
- R5: A store to the same line that is presented in the accepting cycle, or in the cycle after it, cancels the write-back, and `status` becomes 2. A store to a different line in those cycles does not cancel the swap.
- R6: `store_stall` is high in exactly one cycle, the second cycle after acceptance, which is the write-back cycle. It is low at all other times.
- R7: `done` is high for exactly one cycle, the third cycle after acceptance. `old_val`, `status` and `align_err` are valid in that cycle, and `busy` is low in the following cycle.
- R8: A pointer whose bits [2:0] are not zero is misaligned. Such a request makes no memory access and returns `done` in the first cycle after acceptance, with `align_err` high, `status` 3 and `old_val` 0.
- R9: A `start` that is high while `busy` is high is ignored. It produces no extra `done` and no write.
- R10: A store with `st_valid` high writes `st_data` to word `st_addr[1:0]` of line `st_addr[4:2]` on that clock edge. A later compare-and-swap observes the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a compare-and-swap |
| exp_val | input | 64 | Expected word |
| ptr | input | 8 | Byte pointer to the target word |
| new_val | input | 64 | Replacement word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid (one-cycle pulse) |
| old_val | output | 64 | Word observed in memory |
| status | output | 8 | 0 success, 1 mismatch, 2 line written, 3 misaligned |
| align_err | output | 1 | Misaligned pointer flag |
| store_stall | output | 1 | Issuer must hold ordinary stores |
| st_valid | input | 1 | Ordinary store strobe |
| st_addr | input | 5 | Store word address (line, word) |
| st_data | input | 64 | Store data |

## Verification
The swap is tried with a matching expectation, a wrong expectation, a misaligned pointer, and a matching expectation paired with a store to the same line, first in the accepting cycle and then in the compare cycle. These cases separate success, mismatch, the alignment error and the reservation veto. A store to another line during the window shows that the veto is tied to the line and is not global. Each swap is followed by further swaps that read the neighbouring words and the target word back, which shows whether the write landed in the right lane or was correctly withheld. A request repeated while busy, with operands that would otherwise succeed, shows whether the busy guard drops it.

// File: rtl/cas_pkg.sv
package cas_pkg;

   typedef enum logic [1:0] {
      CS_IDLE = 2'd0,
      CS_CMP  = 2'd1,
      CS_WR   = 2'd2,
      CS_FIN  = 2'd3
   } cas_state_e;

   localparam int unsigned CAS_OK         = 0;
   localparam int unsigned CAS_MISMATCH   = 1;
   localparam int unsigned CAS_LOST_LINE  = 2;
   localparam int unsigned CAS_MISALIGNED = 3;

endpackage

// File: rtl/cas_word_lane.sv
// Picks one word out of a line, and builds the line with that word replaced.
module cas_word_lane #(
   parameter  int WORD_W = 64,
   parameter  int WORDS  = 4,
   localparam int SEL_W  = $clog2(WORDS),
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic [LINE_W-1:0] line_in,
   input  logic [SEL_W-1:0]  sel,
   input  logic [WORD_W-1:0] word_in,
   output logic [WORD_W-1:0] word_out,
   output logic [LINE_W-1:0] line_out
);

   always_comb begin
      word_out = '0;
      for (int i = 0; i < WORDS; i++) begin
         if (sel == SEL_W'(i)) word_out = line_in[i*WORD_W +: WORD_W];
      end
   end

   for (genvar g = 0; g < WORDS; g++) begin : g_lane
      assign line_out[g*WORD_W +: WORD_W] =
         (sel == SEL_W'(g)) ? word_in : line_in[g*WORD_W +: WORD_W];
   end

endmodule

// File: rtl/cas_line_locks.sv
// One reservation flag per line: set by a swap read, cleared by any write.
module cas_line_locks #(
   parameter  int LINES = 8,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             clr_st_en,
   input  logic [IDX_W-1:0] clr_st_idx,
   input  logic             clr_rel_en,
   input  logic [IDX_W-1:0] clr_rel_idx,
   input  logic [IDX_W-1:0] q_idx,
   output logic             locked
);

   logic [LINES-1:0] flags;

   // A clear wins over a set on the same edge: the read may be stale.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if ((clr_st_en && clr_st_idx == IDX_W'(i)) ||
                (clr_rel_en && clr_rel_idx == IDX_W'(i)))
               flags[i] <= 1'b0;
            else if (set_en && set_idx == IDX_W'(i))
               flags[i] <= 1'b1;
         end
      end
   end

   assign locked = flags[q_idx];

   p_store_drops_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_st_en |=> !flags[$past(clr_st_idx)])
      else $error("store did not drop line reservation");

endmodule

// File: rtl/cas_line_mem.sv
// Line-wide data store with a word store port, a line write and a registered line read.
module cas_line_mem #(
   parameter  int LINES  = 8,
   parameter  int WORD_W = 64,
   parameter  int WORDS  = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int SEL_W  = $clog2(WORDS),
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              st_en,
   input  logic [IDX_W-1:0]  st_idx,
   input  logic [SEL_W-1:0]  st_sel,
   input  logic [WORD_W-1:0] st_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LINE_W-1:0] rd_line,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line
);

   logic [LINE_W-1:0] mem [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < LINES; i++) mem[i] <= '0;
         rd_line <= '0;
      end else begin
         if (rd_en) rd_line <= mem[rd_idx];
         if (st_en) mem[st_idx][int'(st_sel)*WORD_W +: WORD_W] <= st_data;
         if (wr_en) mem[wr_idx] <= wr_line;
      end
   end

   p_no_dual_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(st_en && wr_en))
      else $error("store collided with swap write-back");

endmodule

// File: rtl/cas_ctrl.sv
// Sequencing of accept, compare, conditional write-back and result.
module cas_ctrl
   import cas_pkg::*;
#(
   parameter  int WORD_W      = 64,
   parameter  int WORDS       = 4,
   parameter  int LINES       = 8,
   parameter  int STAT_W      = 8,
   parameter  bit STALL_EARLY = 1'b0,
   localparam int IDX_W       = $clog2(LINES),
   localparam int SEL_W       = $clog2(WORDS),
   localparam int BYTE_W      = $clog2(WORD_W / 8),
   localparam int ADDR_W      = IDX_W + SEL_W + BYTE_W,
   localparam int LINE_W      = WORD_W * WORDS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] exp_val,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [WORD_W-1:0] new_val,
   input  logic [WORD_W-1:0] obs_word,
   input  logic [LINE_W-1:0] merged_line,
   input  logic              locked,
   output logic [SEL_W-1:0]  sel_q,
   output logic [WORD_W-1:0] rep_q,
   output logic              rd_en,
   output logic [IDX_W-1:0]  rd_idx,
   output logic [IDX_W-1:0]  idx_q,
   output logic              wr_en,
   output logic [LINE_W-1:0] wr_line,
   output logic              rel_en,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] old_val,
   output logic [STAT_W-1:0] status,
   output logic              align_err,
   output logic              store_stall
);

   cas_state_e        state;
   logic [WORD_W-1:0] exp_q;
   logic              match_q;
   logic [LINE_W-1:0] merged_q;
   logic              aligned;
   logic              accept;

   assign aligned = (ptr[BYTE_W-1:0] == '0);
   assign accept  = (state == CS_IDLE) && start;
   assign rd_en   = accept && aligned;
   assign rd_idx  = ptr[ADDR_W-1 -: IDX_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= CS_IDLE;
         exp_q     <= '0;
         rep_q     <= '0;
         idx_q     <= '0;
         sel_q     <= '0;
         match_q   <= 1'b0;
         merged_q  <= '0;
         old_val   <= '0;
         status    <= '0;
         align_err <= 1'b0;
      end else begin
         unique case (state)
            CS_IDLE: if (start) begin
               exp_q     <= exp_val;
               rep_q     <= new_val;
               idx_q     <= rd_idx;
               sel_q     <= ptr[BYTE_W +: SEL_W];
               align_err <= !aligned;
               if (aligned) begin
                  state <= CS_CMP;
               end else begin
                  state   <= CS_FIN;
                  old_val <= '0;
                  status  <= STAT_W'(CAS_MISALIGNED);
               end
            end
            CS_CMP: begin
               match_q  <= (obs_word == exp_q);
               old_val  <= obs_word;
               merged_q <= merged_line;
               state    <= CS_WR;
            end
            CS_WR: begin
               if (!match_q)     status <= STAT_W'(CAS_MISMATCH);
               else if (!locked) status <= STAT_W'(CAS_LOST_LINE);
               else              status <= STAT_W'(CAS_OK);
               state <= CS_FIN;
            end
            default: state <= CS_IDLE;
         endcase
      end
   end

   assign wr_en   = (state == CS_WR) && match_q && locked;
   assign wr_line = merged_q;
   assign rel_en  = (state == CS_WR);
   assign busy    = (state != CS_IDLE);
   assign done    = (state == CS_FIN);

   if (STALL_EARLY) begin : g_stall_early
      assign store_stall = (state == CS_CMP) || (state == CS_WR);
   end else begin : g_stall_late
      assign store_stall = (state == CS_WR);
   end

   p_ops_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(exp_q) && $stable(rep_q) && $stable(idx_q) && $stable(sel_q)))
      else $error("operands changed while busy");

   p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done longer than one cycle");

   p_write_needs_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (old_val == exp_q))
      else $error("write-back without a matching word");

   p_misaligned_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && align_err) |-> (status == STAT_W'(CAS_MISALIGNED)))
      else $error("misaligned result has wrong status");

   p_stall_inside_op_r6: assert property (@(posedge clk) disable iff (!rst_n)
      store_stall |-> busy)
      else $error("stall outside an operation");

endmodule

// File: rtl/cas_seq.sv
module cas_seq #(
   parameter  int WORD_W      = 64,
   parameter  int LINE_W      = 256,
   parameter  int LINES       = 8,
   parameter  int STAT_W      = 8,
   parameter  bit STALL_EARLY = 1'b0,
   localparam int WORDS       = LINE_W / WORD_W,
   localparam int IDX_W       = $clog2(LINES),
   localparam int SEL_W       = $clog2(WORDS),
   localparam int BYTE_W      = $clog2(WORD_W / 8),
   localparam int ADDR_W      = IDX_W + SEL_W + BYTE_W,
   localparam int WA_W        = IDX_W + SEL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] exp_val,
   input  logic [ADDR_W-1:0] ptr,
   input  logic [WORD_W-1:0] new_val,
   output logic              busy,
   output logic              done,
   output logic [WORD_W-1:0] old_val,
   output logic [STAT_W-1:0] status,
   output logic              align_err,
   output logic              store_stall,
   input  logic              st_valid,
   input  logic [WA_W-1:0]   st_addr,
   input  logic [WORD_W-1:0] st_data
);

   if (WORD_W % 8 != 0 || WORD_W < 16) begin : g_bad_word
      $error("WORD_W must be a multiple of 8 and at least 16");
   end
   if (LINE_W % WORD_W != 0 || WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_line
      $error("LINE_W must hold a power-of-two count (>=2) of words");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two, at least 2");
   end
   if (STAT_W < 2) begin : g_bad_stat
      $error("STAT_W must be at least 2");
   end

   logic [LINE_W-1:0] rd_line, merged_line, wr_line;
   logic [WORD_W-1:0] obs_word, rep_q;
   logic [SEL_W-1:0]  sel_q;
   logic [IDX_W-1:0]  rd_idx, idx_q, st_idx;
   logic [SEL_W-1:0]  st_sel;
   logic              rd_en, wr_en, rel_en, locked;

   assign st_idx = st_addr[WA_W-1 -: IDX_W];
   assign st_sel = st_addr[SEL_W-1:0];

   cas_ctrl #(
      .WORD_W(WORD_W), .WORDS(WORDS), .LINES(LINES),
      .STAT_W(STAT_W), .STALL_EARLY(STALL_EARLY)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .exp_val(exp_val), .ptr(ptr), .new_val(new_val),
      .obs_word(obs_word), .merged_line(merged_line), .locked(locked),
      .sel_q(sel_q), .rep_q(rep_q),
      .rd_en(rd_en), .rd_idx(rd_idx), .idx_q(idx_q),
      .wr_en(wr_en), .wr_line(wr_line), .rel_en(rel_en),
      .busy(busy), .done(done), .old_val(old_val), .status(status),
      .align_err(align_err), .store_stall(store_stall)
   );

   cas_word_lane #(.WORD_W(WORD_W), .WORDS(WORDS)) u_lane (
      .line_in(rd_line), .sel(sel_q), .word_in(rep_q),
      .word_out(obs_word), .line_out(merged_line)
   );

   cas_line_locks #(.LINES(LINES)) u_locks (
      .clk(clk), .rst_n(rst_n),
      .set_en(rd_en), .set_idx(rd_idx),
      .clr_st_en(st_valid), .clr_st_idx(st_idx),
      .clr_rel_en(rel_en), .clr_rel_idx(idx_q),
      .q_idx(idx_q), .locked(locked)
   );

   cas_line_mem #(.LINES(LINES), .WORD_W(WORD_W), .WORDS(WORDS)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .st_en(st_valid), .st_idx(st_idx), .st_sel(st_sel), .st_data(st_data),
      .rd_en(rd_en), .rd_idx(rd_idx), .rd_line(rd_line),
      .wr_en(wr_en), .wr_idx(idx_q), .wr_line(wr_line)
   );

   p_store_held_in_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      store_stall |-> !st_valid)
      else $error("store issued during swap write-back");

endmodule

// File: tb/tb_cas_seq.sv
module tb_cas_seq;

   localparam int ADDR_W = 8;
   localparam int WA_W   = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [63:0]       exp_val = '0, new_val = '0, st_data = '0;
   logic [ADDR_W-1:0] ptr = '0;
   logic              st_valid = 1'b0;
   logic [WA_W-1:0]   st_addr = '0;
   logic              busy, done, align_err, store_stall;
   logic [63:0]       old_val;
   logic [7:0]        status;

   cas_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .exp_val(exp_val), .ptr(ptr),
      .new_val(new_val), .busy(busy), .done(done), .old_val(old_val),
      .status(status), .align_err(align_err), .store_stall(store_stall),
      .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
   );

   always #10 clk = ~clk;

   typedef struct {
      logic [63:0] old;
      logic [7:0]  st;
      logic        err;
      string       req;
   } exp_t;

   exp_t        sb[$];
   logic [63:0] model [32];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          finished = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
      end
   endtask

   // Monitor: compares each completed operation with the scoreboard head.
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9", "unexpected done", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(old_val == e.old, e.req, "old_val", old_val, e.old);
            check(status == e.st, e.req, "status", {56'd0, status}, {56'd0, e.st});
            check(align_err == e.err, e.req, "align_err", {63'd0, align_err}, {63'd0, e.err});
         end
      end
   end

   task automatic store(input logic [WA_W-1:0] wa, input logic [63:0] d);
      @(negedge clk);
      st_valid = 1'b1; st_addr = wa; st_data = d;
      model[wa] = d;
      @(negedge clk);
      st_valid = 1'b0;
   endtask

   // sp: 0 no store, 1 store with start, 2 store in the compare cycle
   task automatic do_cas(input logic [63:0] e, input logic [ADDR_W-1:0] p,
                         input logic [63:0] n, input int sp,
                         input logic [WA_W-1:0] swa, input logic [63:0] sd,
                         input bit hold_start, input string req);
      exp_t        x;
      logic [WA_W-1:0] wa;
      bit          mis, conflict;
      wa  = p[ADDR_W-1:3];
      mis = (p[2:0] != 3'b0);
      x.req = req;
      if (mis) begin
         x.old = '0; x.st = 8'd3; x.err = 1'b1;
      end else begin
         x.old = model[wa]; x.err = 1'b0;
         conflict = (sp != 0) && (swa[WA_W-1:2] == wa[WA_W-1:2]);
         if (model[wa] != e)  x.st = 8'd1;
         else if (conflict)   x.st = 8'd2;
         else begin x.st = 8'd0; model[wa] = n; end
      end
      if (sp != 0) model[swa] = sd;
      sb.push_back(x);
      @(negedge clk);
      start = 1'b1; exp_val = e; ptr = p; new_val = n;
      if (sp == 1) begin st_valid = 1'b1; st_addr = swa; st_data = sd; end
      @(negedge clk);
      st_valid = 1'b0;
      if (mis) begin
         start = 1'b0;
         check(done == 1'b1, "R8", "done one cycle after accept", {63'd0, done}, 64'd1);
         @(negedge clk);
         check(busy == 1'b0, "R8", "idle after error", {63'd0, busy}, 64'd0);
         return;
      end
      if (hold_start) begin
         exp_val = model[wa]; new_val = 64'hDEAD_0000_BEEF_0000;
      end else begin
         start = 1'b0;
      end
      if (sp == 2) begin st_valid = 1'b1; st_addr = swa; st_data = sd; end
      check(busy && !store_stall, "R6", "no stall in compare cycle",
            {62'd0, busy, store_stall}, 64'd2);
      @(negedge clk);
      start = 1'b0; st_valid = 1'b0;
      check(store_stall == 1'b1, "R6", "stall in write cycle", {63'd0, store_stall}, 64'd1);
      @(negedge clk);
      check(done && !store_stall, "R7", "done in third cycle", {62'd0, done, store_stall}, 64'd2);
      @(negedge clk);
      check(!done && !busy, "R7", "idle after done", {62'd0, done, busy}, 64'd0);
   endtask

   function automatic logic [ADDR_W-1:0] pa(input int line, input int word);
      return ADDR_W'((line * 4 + word) * 8);
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(!busy && !done && !store_stall && !align_err, "R1", "reset outputs",
            {60'd0, busy, done, store_stall, align_err}, 64'd0);
      for (int i = 0; i < 32; i++) model[i] = '0;
      do_cas(64'd1, pa(6, 2), 64'd9, 0, '0, '0, 1'b0, "R1");
      // R10: preload through the store port
      for (int i = 0; i < 32; i++) store(WA_W'(i), 64'hA5A5_0000_0000_0000 | 64'(i * 32'h1111));
      // R2/R3: success, then read back target and neighbour
      do_cas(model[9], pa(2, 1), 64'h1234_5678_9ABC_DEF0, 0, '0, '0, 1'b0, "R3");
      do_cas(64'h1234_5678_9ABC_DEF0, pa(2, 1), 64'h0F0F, 0, '0, '0, 1'b0, "R2");
      do_cas(~model[8], pa(2, 0), 64'd0, 0, '0, '0, 1'b0, "R2");
      do_cas(~model[10], pa(2, 2), 64'd0, 0, '0, '0, 1'b0, "R2");
      // R4: mismatch leaves memory alone
      do_cas(64'h5555, pa(5, 3), 64'h7777, 0, '0, '0, 1'b0, "R4");
      do_cas(64'h7777, pa(5, 3), 64'h1, 0, '0, '0, 1'b0, "R4");
      // R5: same-line store in compare cycle cancels
      do_cas(model[13], pa(3, 1), 64'hAAAA, 2, WA_W'(14), 64'hC0DE, 1'b0, "R5");
      do_cas(64'hAAAA, pa(3, 1), 64'h2, 0, '0, '0, 1'b0, "R5");
      do_cas(64'hC0DE, pa(3, 2), 64'h3, 0, '0, '0, 1'b0, "R10");
      // R5: same-word store with start cancels, read sees pre-store value
      do_cas(model[4], pa(1, 0), 64'hBBBB, 1, WA_W'(4), 64'hF00D, 1'b0, "R5");
      do_cas(64'hF00D, pa(1, 0), 64'h4, 0, '0, '0, 1'b0, "R5");
      // R5: other-line store does not cancel
      do_cas(model[1], pa(0, 1), 64'hCCCC, 2, WA_W'(20), 64'hFACE, 1'b0, "R5");
      do_cas(64'hCCCC, pa(0, 1), 64'h5, 0, '0, '0, 1'b0, "R5");
      // R8: misaligned pointer
      do_cas(model[24], pa(6, 0) | 8'h4, 64'hEEEE, 0, '0, '0, 1'b0, "R8");
      do_cas(64'hEEEE, pa(6, 0), 64'h6, 0, '0, '0, 1'b0, "R8");
      // R9: start held while busy is ignored
      do_cas(64'hFFFF, pa(4, 2), 64'h11, 0, '0, '0, 1'b1, "R9");
      do_cas(64'hDEAD_0000_BEEF_0000, pa(4, 2), 64'h12, 0, '0, '0, 1'b0, "R9");
      repeat (4) @(negedge clk);
      check(sb.size() == 0, "R9", "scoreboard drained", 64'(sb.size()), 64'd0);
      // R2: every lane of the last line
      for (int w = 0; w < 4; w++)
         do_cas(model[28 + w], pa(7, w), 64'h7000 + 64'(w), 0, '0, '0, 1'b0, "R2");
      for (int w = 0; w < 4; w++)
         do_cas(64'h7000 + 64'(w), pa(7, w), 64'd0, 0, '0, '0, 1'b0, "R2");
      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule